// File: doc/BRIEF.md
# Multi-Mode Slice Access Memory

This block is a square bit array of N words, each N bits wide (N = 256 by default). Every access moves N bits at once over a dedicated read bus and a dedicated write bus. The access mode and the address together pick a stencil: which N stored bits take part in the access, and which bus lane each of them uses. One array can therefore be read and written across words (one bit of every word) or along a word (all bits of one word). It also supports three record-oriented patterns, which treat the array as N/8 records of N bytes.

For the record patterns, record r occupies words 8r to 8r+7. Its byte j (0 to N-1) is stored in word 8r + j/B, where B = N/8 is the number of bytes per word. Within that word the byte sits in byte lane (j + r) mod B, which covers bits 8·lane to 8·lane+7. Because the lane is rotated by the record index, reading a record differs from reading a plain word. Reads are synchronous with one cycle of latency. A write access also returns the contents that the stencil held before the write. A write is either unmasked (all N accessed bits change) or masked (only the lanes whose mask bit is 1 change).

Top module: `slice_access_mem`

## Requirements
- R1: After reset, rd_data is all zeros. In any cycle without acc_en, rd_data keeps its value.
- R2: An access with acc_en high updates rd_data at the next clock edge with the stencil's contents. On a write access, this is the content from before the write.
- R3: mode_sel 3'b000 (bit slice): lane k carries bit `addr` of word k.
- R4: mode_sel 3'b001 (word): lane k carries bit k of word `addr`.
- R5: mode_sel 3'b010 (record bytes): addr[2:0] is a chunk c and the upper address bits are a record r. Bus byte k carries byte c·B+k of record r, which is word 8r+c, byte lane (k+r) mod B.
- R6: mode_sel 3'b011 (byte column): addr is a byte index j. Bus byte r carries byte j of record r.
- R7: mode_sel 3'b1xx (bit of each byte, all four codes alike): lane k carries bit bit_sel of byte k of record r.
- R8: bit_sel has no effect in the modes 3'b000 to 3'b011.
- R9: An unmasked write (masked_wr = 0) stores all N lanes of wr_data, whatever wr_mask holds.
- R10: A masked write (masked_wr = 1) stores lane k only where wr_mask[k] is 1. All other accessed bits keep their value.
- R11: wr_en without acc_en changes neither the array nor rd_data.
- R12: In the bit-of-each-byte mode, r is addr modulo N/8, and the upper address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the read register |
| acc_en | input | 1 | Perform an access this cycle |
| wr_en | input | 1 | The access also writes |
| masked_wr | input | 1 | 1 = masked write, 0 = unmasked write |
| mode_sel | input | 3 | Stencil mode |
| addr | input | log2(N) | Stencil position |
| bit_sel | input | 3 | Bit within each byte for mode 3'b1xx |
| wr_data | input | N | Write bus |
| wr_mask | input | N | Write-mask bus |
| rd_data | output | N | Read bus, registered |

## Verification
The array is first filled with distinct word patterns. Every address in every mode is then read back, so a lane that is swapped between words, bits or byte lanes produces a wrong vector. Bit-of-each-byte reads cover every bit selector, all four alias codes and addresses beyond the record count. This separates the rotated record layout from plain word reads, and the record index from the ignored address bits. Writes come in every mode with masks of all zeros, all ones and mixed patterns. Each write is followed by reads of its own stencil and a full word-mode readback, which tells a masked write from an unmasked one and catches bits written outside the stencil. Cycles with wr_en but no acc_en confirm that neither the array nor the read bus moves.

// File: rtl/sam_pkg.sv
package sam_pkg;

    typedef enum logic [2:0] {
        ACC_SLICE     = 3'b000,
        ACC_WORD      = 3'b001,
        ACC_RECBYTES  = 3'b010,
        ACC_BYTECOL   = 3'b011,
        ACC_BITOFBYTE = 3'b100
    } acc_mode_e;

    localparam int unsigned BYTE_BITS = 8;
    localparam int unsigned REC_WORDS = 8;

    // Every code with the top bit set selects the bit-of-each-byte stencil.
    function automatic acc_mode_e decode_mode(input logic [2:0] raw);
        if (raw[2]) begin
            return ACC_BITOFBYTE;
        end
        return acc_mode_e'(raw);
    endfunction

endpackage

// File: rtl/sam_stencil.sv
module sam_stencil
    import sam_pkg::*;
#(
    parameter int unsigned N = 256
) (
    input  acc_mode_e                      mode,
    input  logic [$clog2(N)-1:0]           addr,
    input  logic [2:0]                     bsel,
    output logic [N-1:0][$clog2(N)-1:0]    word_idx,
    output logic [N-1:0][$clog2(N)-1:0]    bit_idx
);

    localparam int unsigned AW = $clog2(N);
    localparam int unsigned BW = AW - 3;   // byte lanes per word and record count are both 2**BW

    for (genvar k = 0; k < int'(N); k++) begin : g_lane
        localparam logic [AW-1:0] K     = AW'(k);
        localparam logic [BW-1:0] KBYTE = K[AW-1:3];
        localparam logic [2:0]    KBIT  = K[2:0];

        logic [BW-1:0] rec;
        logic [BW-1:0] lane;
        logic [2:0]    chunk;
        logic [AW-1:0] w_l;
        logic [AW-1:0] b_l;

        always_comb begin
            rec   = '0;
            lane  = '0;
            chunk = '0;
            w_l   = '0;
            b_l   = '0;
            unique case (mode)
                ACC_SLICE: begin
                    w_l = K;
                    b_l = addr;
                end
                ACC_WORD: begin
                    w_l = addr;
                    b_l = K;
                end
                ACC_RECBYTES: begin
                    rec   = addr[AW-1:3];
                    chunk = addr[2:0];
                    lane  = KBYTE + rec;
                    w_l   = {rec, chunk};
                    b_l   = {lane, KBIT};
                end
                ACC_BYTECOL: begin
                    rec   = KBYTE;
                    chunk = addr[AW-1:BW];
                    lane  = addr[BW-1:0] + rec;
                    w_l   = {rec, chunk};
                    b_l   = {lane, KBIT};
                end
                ACC_BITOFBYTE: begin
                    rec   = addr[BW-1:0];
                    chunk = K[AW-1:BW];
                    lane  = K[BW-1:0] + rec;
                    w_l   = {rec, chunk};
                    b_l   = {lane, bsel};
                end
                default: begin
                    w_l = '0;
                    b_l = '0;
                end
            endcase
        end

        assign word_idx[k] = w_l;
        assign bit_idx[k]  = b_l;
    end

endmodule

// File: rtl/sam_store.sv
module sam_store #(
    parameter int unsigned N = 256
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           acc,
    input  logic                           wr,
    input  logic                           masked,
    input  logic [N-1:0][$clog2(N)-1:0]    word_idx,
    input  logic [N-1:0][$clog2(N)-1:0]    bit_idx,
    input  logic [N-1:0]                   wdata,
    input  logic [N-1:0]                   wmask,
    output logic [N-1:0]                   rdata
);

    logic [N-1:0] cells [N];
    logic [N-1:0] lane_we;

    always_comb begin
        if (acc && wr) begin
            lane_we = masked ? wmask : '1;
        end else begin
            lane_we = '0;
        end
    end

    // Registered read; nonblocking update gives the pre-write contents on a write access.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (acc) begin
            for (int k = 0; k < int'(N); k++) begin
                rdata[k] <= cells[word_idx[k]][bit_idx[k]];
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < int'(N); k++) begin
            if (lane_we[k]) begin
                cells[word_idx[k]][bit_idx[k]] <= wdata[k];
            end
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> rdata == '0);

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(rdata));

endmodule

// File: rtl/slice_access_mem.sv
module slice_access_mem
    import sam_pkg::*;
#(
    parameter int unsigned N = 256
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc_en,
    input  logic                   wr_en,
    input  logic                   masked_wr,
    input  logic [2:0]             mode_sel,
    input  logic [$clog2(N)-1:0]   addr,
    input  logic [2:0]             bit_sel,
    input  logic [N-1:0]           wr_data,
    input  logic [N-1:0]           wr_mask,
    output logic [N-1:0]           rd_data
);

    localparam int unsigned AW = $clog2(N);

    acc_mode_e                 mode_q;
    logic [N-1:0][AW-1:0]      word_idx;
    logic [N-1:0][AW-1:0]      bit_idx;

    assign mode_q = decode_mode(mode_sel);

    sam_stencil #(.N(N)) u_stencil (
        .mode     (mode_q),
        .addr     (addr),
        .bsel     (bit_sel),
        .word_idx (word_idx),
        .bit_idx  (bit_idx)
    );

    sam_store #(.N(N)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc_en),
        .wr       (wr_en),
        .masked   (masked_wr),
        .word_idx (word_idx),
        .bit_idx  (bit_idx),
        .wdata    (wr_data),
        .wmask    (wr_mask),
        .rdata    (rd_data)
    );

    // R9: an unmasked write followed by a read of the same stencil returns the written bus.
    a_r9_unmasked_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !wr_en && $past(acc_en && wr_en && !masked_wr)
         && mode_sel == $past(mode_sel) && addr == $past(addr) && bit_sel == $past(bit_sel))
        |=> rd_data == $past(wr_data, 2));

    // R10: a masked write merges new lanes with the old contents returned by the write.
    a_r10_masked_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !wr_en && $past(acc_en && wr_en && masked_wr)
         && mode_sel == $past(mode_sel) && addr == $past(addr) && bit_sel == $past(bit_sel))
        |=> rd_data == (($past(wr_data, 2) & $past(wr_mask, 2))
                       | ($past(rd_data) & ~$past(wr_mask, 2))));

endmodule

// File: tb/slice_access_mem_test.sv
`timescale 1ns/1ps
module slice_access_mem_test;

    localparam int N  = 16;
    localparam int AW = 4;
    localparam int B  = N / 8;
    localparam int RC = N / 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           acc_en = 1'b0;
    logic           wr_en = 1'b0;
    logic           masked_wr = 1'b0;
    logic [2:0]     mode_sel = 3'b000;
    logic [AW-1:0]  addr = '0;
    logic [2:0]     bit_sel = 3'b000;
    logic [N-1:0]   wr_data = '0;
    logic [N-1:0]   wr_mask = '0;
    logic [N-1:0]   rd_data;

    logic [N-1:0]   shm [N];
    logic [N-1:0]   last_rd;
    int             nvec = 0;
    int             nerr = 0;
    bit             done = 0;

    always #10 clk = ~clk;

    slice_access_mem #(.N(N)) uut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .wr_en(wr_en),
        .masked_wr(masked_wr), .mode_sel(mode_sel), .addr(addr),
        .bit_sel(bit_sel), .wr_data(wr_data), .wr_mask(wr_mask),
        .rd_data(rd_data)
    );

    function automatic logic [N-1:0] pat(input int s);
        int v;
        v = s * 40503 + 12345;
        v = v ^ (s << 7) ^ (v >> 5);
        return v[N-1:0];
    endfunction

    // Stencil position k -> stored word / bit, from the record layout arithmetic.
    function automatic int ew(input int md, input int ad, input int k);
        int r, j;
        if (md >= 4)      begin r = ad % RC; j = k;                   return 8*r + j/B; end
        else if (md == 0) return k;
        else if (md == 1) return ad;
        else if (md == 2) begin r = ad / 8; j = (ad % 8)*B + k/8;     return 8*r + j/B; end
        else              begin r = k / 8; j = ad;                    return 8*r + j/B; end
    endfunction

    function automatic int eb(input int md, input int ad, input int bs, input int k);
        int r, j;
        if (md >= 4)      begin r = ad % RC; j = k;                   return 8*((j+r)%B) + bs; end
        else if (md == 0) return ad;
        else if (md == 1) return k;
        else if (md == 2) begin r = ad / 8; j = (ad % 8)*B + k/8;     return 8*((j+r)%B) + k%8; end
        else              begin r = k / 8; j = ad;                    return 8*((j+r)%B) + k%8; end
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at a falling edge.
    task automatic access(input bit acc, input bit wr, input bit msk, input int md, input int ad,
                          input int bs, input logic [N-1:0] wd, input logic [N-1:0] wm,
                          input bit chk, input string tag);
        logic [N-1:0] expv;
        if (acc) begin
            for (int k = 0; k < N; k++) expv[k] = shm[ew(md, ad, k)][eb(md, ad, bs, k)];
        end else begin
            expv = last_rd;
        end
        acc_en = acc; wr_en = wr; masked_wr = msk;
        mode_sel = md[2:0]; addr = ad[AW-1:0]; bit_sel = bs[2:0];
        wr_data = wd; wr_mask = wm;
        @(posedge clk);
        @(negedge clk);
        if (chk) check(tag, rd_data, expv);
        last_rd = rd_data;
        if (acc && wr) begin
            for (int k = 0; k < N; k++)
                if (!msk || wm[k]) shm[ew(md, ad, k)][eb(md, ad, bs, k)] = wd[k];
        end
        acc_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic read(input int md, input int ad, input int bs, input string tag);
        access(1, 0, 0, md, ad, bs, '0, '0, 1, tag);
    endtask

    task automatic word_sweep(input string tag);
        for (int w = 0; w < N; w++) read(1, w, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        string tg;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset", rd_data, '0);
        last_rd = rd_data;

        // Fill through unmasked word writes with an all-zero mask (R9: mask ignored).
        for (int w = 0; w < N; w++) access(1, 1, 0, 1, w, 0, pat(w), '0, 0, "");
        word_sweep("R9 fill");

        // Read every stencil in the four low modes.
        for (int md = 0; md < 4; md++) begin
            for (int ad = 0; ad < N; ad++) begin
                case (md)
                    0: tg = "R3 slice";
                    1: tg = "R4 word";
                    2: tg = "R5 recbytes";
                    default: tg = "R6 bytecol";
                endcase
                read(md, ad, ad % 8, tg);
            end
        end
        // R8: bit_sel variations in those modes.
        for (int md = 0; md < 4; md++)
            for (int ad = 0; ad < N; ad += 5)
                for (int bs = 1; bs < 8; bs += 3) read(md, ad, bs, "R8 bitsel");
        // R7 / R12: every bit selector, alias codes, addresses beyond the record count.
        for (int ad = 0; ad < N; ad++)
            for (int bs = 0; bs < 8; bs++)
                read(4 + (bs % 4), ad, bs, (ad >= RC) ? "R12 addr wrap" : "R7 bitofbyte");

        // R1 / R11: idle cycles, with and without wr_en.
        access(0, 0, 0, 1, 3, 0, '0, '0, 1, "R1 hold");
        access(0, 1, 0, 1, 3, 0, 16'hA5C3, '1, 1, "R11 idle wr");
        access(0, 1, 1, 3, 7, 2, 16'h5A3C, '1, 1, "R11 idle wr");
        word_sweep("R11 unchanged");

        // Unmasked writes in every mode: write returns old data (R2), readback (R9).
        for (int md = 0; md < 5; md++)
            for (int ad = 1; ad < N; ad += 6) begin
                access(1, 1, 0, md, ad, ad % 8, pat(100 + md*16 + ad), pat(7 + ad), 1, "R2 old data");
                read(md, ad, ad % 8, "R9 unmasked");
            end
        word_sweep("R9 array");

        // Masked writes: zero, full and mixed masks.
        for (int md = 0; md < 5; md++)
            for (int ad = 2; ad < N; ad += 5)
                for (int mi = 0; mi < 3; mi++) begin
                    logic [N-1:0] wm;
                    wm = (mi == 0) ? '0 : (mi == 1) ? '1 : pat(300 + ad + md);
                    access(1, 1, 1, md, ad, (ad + mi) % 8, pat(200 + md*32 + ad*3 + mi), wm, 1, "R2 old data");
                    read(md, ad, (ad + mi) % 8, "R10 masked");
                end
        word_sweep("R10 array");
        for (int ad = 0; ad < N; ad++) read(0, ad, 0, "R3 slice after writes");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule